// File: doc/BRIEF.md
# Servo Command Receiver

This block is a write-only serial slave that accepts 16-bit command words from a host controller. It turns each word into a position setting for one of eight servo channels. The serial clock, data and active-low select come from outside. Each one passes through a synchroniser into the fast system clock, and the data bit is captured on each rising serial-clock edge, most significant bit first.

When select returns high after exactly sixteen bits, the block decodes two fields from the word: a channel number, and a signed angle in half-degree steps. It turns the angle into an offset-binary code and writes that code to the channel's holding register. A separate period-start strobe copies every holding register into the active setting outputs in one cycle. A pulse generator downstream therefore sees new positions only at the start of a servo period.

A one-cycle write pulse and the decoded channel number are also driven out, so that each accepted word can be observed.

Top module: `servo_cmd_rx`

## Requirements
- R1: After reset every active setting is 0x80, the code for centre position, and wr_valid_o is low.
- R2: A word is 16 bits, sent most significant bit first. SCK idles low and MOSI is sampled on each rising SCK edge while cs_ni is low.
- R3: Word bits 10:8 select channel 0..7. Bits 15:11 have no effect on which channel is written or on the value stored.
- R4: The stored code is word bits 7:0, read as a two's complement angle, with bit 7 inverted and bits 6:0 unchanged. For example, 0x05 stores 0x85, 0xFF stores 0x7F, 0x80 stores 0x00 and 0x7F stores 0xFF.
- R5: When cs_ni rises after a complete word, wr_valid_o goes high for exactly one clock and wr_chan_o shows the channel from bits 10:8.
- R6: Active settings change only in the clock after period_start_i is high. Every channel is then loaded from its holding register in that same clock, and a write that is not followed by a strobe leaves every output unchanged.
- R7: A transfer that ends with fewer or more than 16 rising SCK edges writes no register and gives no wr_valid_o pulse.
- R8: The bit count clears whenever cs_ni is high, so a complete word that follows a discarded transfer is accepted normally.
- R9: If a channel is written twice before a strobe, the strobe loads the later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from the host |
| cs_ni | input | 1 | Select, active low |
| period_start_i | input | 1 | Strobe that loads all active settings |
| setting_o | output | NUM_CH*ANGLE_W (64) | Active settings; channel n occupies bits n*8+7:n*8 |
| wr_valid_o | output | 1 | One-cycle pulse for each accepted word |
| wr_chan_o | output | CH_W (3) | Channel of the accepted word |

## Verification
The bench builds the block with its default parameters: eight channels, an 8-bit angle, a 16-bit word and two synchroniser stages. With these values the full 3-bit channel field is used, and the bench can reach the inverted-sign codes at both ends of the signed range. It also sends discarded transfers of 8 and 17 bits, which exercise both sides of the exact-length check. Serial clocking runs at one eighth of the system clock, so the synchroniser latency and edge detection are covered at a realistic speed margin.

// File: rtl/servo_cmd_pkg.sv
`timescale 1ns/1ps
package servo_cmd_pkg;
  localparam int unsigned DEF_NUM_CH  = 8;
  localparam int unsigned DEF_ANGLE_W = 8;
  localparam int unsigned DEF_FRAME_W = 16;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/servo_cmd_sync.sv
`timescale 1ns/1ps
module servo_cmd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= {STAGES{RST_VAL}};
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/servo_cmd_shift.sv
`timescale 1ns/1ps
module servo_cmd_shift #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned ANGLE_W = 8,
  parameter int unsigned CH_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_s_i,
  input  logic               mosi_s_i,
  input  logic               cs_s_i,
  output logic               frame_valid_o,
  output logic [CH_W-1:0]    frame_chan_o,
  output logic [ANGLE_W-1:0] frame_angle_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sck_q, cs_q;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sck_rise, cs_rise;

  assign sck_rise = sck_s_i & ~sck_q;
  assign cs_rise  = cs_s_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q         <= 1'b0;
      cs_q          <= 1'b1;
      shift_q       <= '0;
      cnt_q         <= '0;
      frame_valid_o <= 1'b0;
      frame_chan_o  <= '0;
      frame_angle_o <= '0;
    end else begin
      sck_q         <= sck_s_i;
      cs_q          <= cs_s_i;
      frame_valid_o <= 1'b0;
      if (cs_s_i) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        shift_q <= {shift_q[FRAME_W-2:0], mosi_s_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;  // saturate past full
      end
      if (cs_rise && cnt_q == CNT_FULL) begin
        frame_valid_o <= 1'b1;
        frame_chan_o  <= shift_q[ANGLE_W +: CH_W];
        frame_angle_o <= shift_q[ANGLE_W-1:0];
      end
    end
  end

  // R7: a frame is only accepted with an exact bit count
  a_r7_exact_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(cnt_q) == CNT_FULL);
  // R5: accept pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  // R8: count cleared while deselected
  a_r8_count_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && cs_q) |=> cnt_q == '0);
endmodule

// File: rtl/servo_cmd_bank.sv
`timescale 1ns/1ps
module servo_cmd_bank #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ANGLE_W = 8,
  parameter int unsigned CH_W    = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [CH_W-1:0]                 wr_chan_i,
  input  logic [ANGLE_W-1:0]              wr_angle_i,
  input  logic                            load_i,
  output logic [NUM_CH-1:0][ANGLE_W-1:0]  setting_o
);
  localparam logic [ANGLE_W-1:0] CENTER = ANGLE_W'(1) << (ANGLE_W - 1);

  logic [NUM_CH-1:0][ANGLE_W-1:0] hold_q, act_q;
  logic [NUM_CH-1:0]              sel;
  logic [ANGLE_W-1:0]             wr_code;

  // signed angle to offset binary
  assign wr_code = {~wr_angle_i[ANGLE_W-1], wr_angle_i[ANGLE_W-2:0]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    assign sel[ch] = wr_en_i && (wr_chan_i == CH_W'(ch));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= {NUM_CH{CENTER}};
      act_q  <= {NUM_CH{CENTER}};
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (sel[ch]) hold_q[ch] <= wr_code;
      end
      if (load_i) act_q <= hold_q;
    end
  end

  assign setting_o = act_q;

  // R6: outputs frozen between strobes
  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
  // R6: strobe loads every channel at once
  a_r6_load_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> act_q == $past(hold_q));
  // R4: written code has the sign bit inverted
  a_r4_offset_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(wr_chan_i) < NUM_CH) |=>
      hold_q[$past(wr_chan_i)] == {~$past(wr_angle_i[ANGLE_W-1]), $past(wr_angle_i[ANGLE_W-2:0])});
endmodule

// File: rtl/servo_cmd_rx.sv
`timescale 1ns/1ps
module servo_cmd_rx
  import servo_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned ANGLE_W = DEF_ANGLE_W,
  parameter int unsigned FRAME_W = DEF_FRAME_W,
  parameter int unsigned SYNC_N  = DEF_SYNC,
  localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sck_i,
  input  logic                      mosi_i,
  input  logic                      cs_ni,
  input  logic                      period_start_i,
  output logic [NUM_CH*ANGLE_W-1:0] setting_o,
  output logic                      wr_valid_o,
  output logic [CH_W-1:0]           wr_chan_o
);
  logic                           sck_s, mosi_s, cs_s;
  logic                           frame_valid;
  logic [CH_W-1:0]                frame_chan;
  logic [ANGLE_W-1:0]             frame_angle;
  logic [NUM_CH-1:0][ANGLE_W-1:0] setting_w;

  servo_cmd_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, mosi_i, sck_i}),
    .q_o   ({cs_s, mosi_s, sck_s})
  );

  servo_cmd_shift #(.FRAME_W(FRAME_W), .ANGLE_W(ANGLE_W), .CH_W(CH_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sck_s_i      (sck_s),
    .mosi_s_i     (mosi_s),
    .cs_s_i       (cs_s),
    .frame_valid_o(frame_valid),
    .frame_chan_o (frame_chan),
    .frame_angle_o(frame_angle)
  );

  servo_cmd_bank #(.NUM_CH(NUM_CH), .ANGLE_W(ANGLE_W), .CH_W(CH_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (frame_valid),
    .wr_chan_i (frame_chan),
    .wr_angle_i(frame_angle),
    .load_i    (period_start_i),
    .setting_o (setting_w)
  );

  assign setting_o  = setting_w;
  assign wr_valid_o = frame_valid;
  assign wr_chan_o  = frame_chan;
endmodule

// File: tb/servo_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module servo_cmd_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1, pstart = 1'b0;
  logic [63:0] setting;
  logic        wr_valid;
  logic [2:0]  wr_chan;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] exp_act [8];
  logic [7:0] exp_hold [8];

  always #2.5 clk = ~clk;

  servo_cmd_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_ni(cs_n),
    .period_start_i(pstart), .setting_o(setting), .wr_valid_o(wr_valid), .wr_chan_o(wr_chan)
  );

  // {frame[15:0], channel[2:0], expected code[7:0]}
  localparam logic [26:0] VEC [8] = '{
    {16'h0000, 3'd0, 8'h80}, {16'h0105, 3'd1, 8'h85},
    {16'h02FF, 3'd2, 8'h7F}, {16'h0380, 3'd3, 8'h00},
    {16'h047F, 3'd4, 8'hFF}, {16'hFD3C, 3'd5, 8'hBC},
    {16'h06C4, 3'd6, 8'h44}, {16'hAF10, 3'd7, 8'h90}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // send nbits of frame MSB first; returns pulse count and last channel seen
  task automatic send(input logic [15:0] frame, input int nbits, output int pulses, output logic [2:0] ch);
    pulses = 0; ch = '0;
    @(negedge clk); cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? frame[15-i] : 1'b0;
      wait_clk(4); sck = 1'b1;
      wait_clk(4); sck = 1'b0;
      if (wr_valid) pulses++;
    end
    wait_clk(4); cs_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wr_valid) begin pulses++; ch = wr_chan; end
    end
  endtask

  task automatic strobe();
    @(negedge clk); pstart = 1'b1;
    @(negedge clk); pstart = 1'b0;
    for (int c = 0; c < 8; c++) exp_act[c] = exp_hold[c];
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 8; c++)
      chk(setting[c*8 +: 8] == exp_act[c], req, 64'(setting[c*8 +: 8]), 64'(exp_act[c]));
  endtask

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    logic [2:0] ch;
    for (int c = 0; c < 8; c++) begin exp_act[c] = 8'h80; exp_hold[c] = 8'h80; end
    wait_clk(3);
    // R1 reset state
    chk(setting == {8{8'h80}}, "R1 reset settings", setting, {8{8'h80}});
    chk(wr_valid == 1'b0, "R1 reset wr_valid", 64'(wr_valid), 0);
    rst_n = 1'b1;
    wait_clk(3);
    check_all("R1 after release");

    // table: R2 R3 R4 R5, no strobe -> outputs unchanged (R6)
    for (int v = 0; v < 8; v++) begin
      send(VEC[v][26:11], 16, p, ch);
      chk(p == 1, "R5 one pulse", 64'(p), 1);
      chk(ch == VEC[v][10:8], "R3 channel decode", 64'(ch), 64'(VEC[v][10:8]));
      exp_hold[VEC[v][10:8]] = VEC[v][7:0];
      check_all("R6 no change before strobe");
    end
    strobe();
    check_all("R4 R2 stored codes after strobe");

    // R6 strobe with no writes keeps values
    strobe();
    check_all("R6 idle strobe");

    // R7 short transfer discarded
    send(16'h0011, 8, p, ch);
    chk(p == 0, "R7 short no pulse", 64'(p), 0);
    strobe();
    check_all("R7 short no write");

    // R7 long transfer discarded
    send(16'h0122, 17, p, ch);
    chk(p == 0, "R7 long no pulse", 64'(p), 0);
    strobe();
    check_all("R7 long no write");

    // R8 full frame right after an aborted one
    send(16'h0333, 5, p, ch);
    send(16'h0333, 16, p, ch);
    chk(p == 1 && ch == 3'd3, "R8 accepted after abort", 64'({p[3:0], ch}), 64'({4'd1, 3'd3}));
    exp_hold[3] = 8'hB3;
    strobe();
    check_all("R8 value after abort");

    // R9 last write before strobe wins
    send(16'h0210, 16, p, ch);
    exp_hold[2] = 8'h90;
    send(16'h02F0, 16, p, ch);
    exp_hold[2] = 8'h70;
    check_all("R9 unchanged before strobe");
    strobe();
    chk(setting[23:16] == 8'h70, "R9 later write wins", 64'(setting[23:16]), 64'h70);

    // R3 upper bits ignored: same low bits, different high bits
    send(16'h5125, 16, p, ch);
    chk(ch == 3'd1, "R3 upper bits ignored chan", 64'(ch), 1);
    exp_hold[1] = 8'hA5;
    strobe();
    check_all("R3 upper bits ignored value");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule